// File: doc/BRIEF.md
# Double-Buffered Serial Character Transmitter

This block sends 8-bit characters on a single asynchronous line that rests high. A character goes out as a frame of ten bits: a low start bit, the eight data bits with the least significant bit first, and a high stop bit. Bit timing comes from an external enable that pulses once per bit period. The block has no baud generator of its own.

Two registers sit in the path. A holding register takes writes from software. A shift register drives the line. A character moves from the holding register into the shift register as soon as the shift register is free, so the next character can be written while the current one is still going out. Consecutive characters then leave the line with no idle time between them. A status flag reports that the holding register is empty. A second status output reports that a frame is on the line. Clearing the enable input stops everything at once.

Top module: `serial_tx_dbuf`

## Requirements
- R1: A frame is a start bit at 0, then data bits 0 through 7 in that order (least significant first), then a stop bit at 1. A frame begins at the first bit tick after the character reaches an idle shift register.
- R2: While the enable is high, `tx_o` changes only on a clock edge where `bit_tick_i` is high, so each bit stays on the line for exactly one tick period.
- R3: Whenever `busy_o` is 0, `tx_o` is 1. After reset, `tx_o` is 1, `tx_empty_o` is 1 and `busy_o` is 0.
- R4: A write accepted while the shift register is idle drives `tx_empty_o` to 0 for exactly one cycle after the write edge. On the next edge the character moves to the shift register, and `tx_empty_o` returns to 1.
- R5: A character written while a frame is being sent is held. Its start bit begins on the same tick that ends the previous stop bit. Frame starts of back-to-back characters are therefore exactly 10 ticks apart.
- R6: A write while `tx_empty_o` is 0 is ignored, and the character already pending is sent unchanged.
- R7: On the edge after `tx_en_i` is seen low, any frame is abandoned, `tx_o` is 1, `busy_o` is 0 and `tx_empty_o` is 1. While the enable is low, writes and ticks have no effect, and no frame appears after the enable is raised again.
- R8: `busy_o` is 1 from the edge that starts the start bit until the tick that ends the stop bit. It changes only on tick edges or on an abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmit enable; low aborts and clears |
| bit_tick_i | input | 1 | One-cycle pulse per bit period |
| wr_i | input | 1 | Write strobe for the holding register |
| wr_data_i | input | 8 | Character to send |
| tx_empty_o | output | 1 | 1 when the holding register can accept a write |
| busy_o | output | 1 | 1 while a frame is on the line |
| tx_o | output | 1 | Serial line, idle high |

## Verification
The empty flag falls on the edge that captures a write. It rises again one edge later if the shift register is idle, so the bench reads it at the first and second falling edges after the write strobe. Line and busy changes are due on the edge where the tick is high. The bench requests a tick on a falling edge and samples three falling edges later, after that edge has passed. It then samples again two cycles later, with no tick in between, to confirm the line held. For streamed characters, a receiver model reads the line at every tick edge, before the edge updates it. It checks each stop bit, the decoded data, and that the start bits of consecutive frames are exactly ten ticks apart.

// File: rtl/stx_pkg.sv
package stx_pkg;
  typedef enum logic [1:0] {
    SH_IDLE  = 2'd0,
    SH_ARMED = 2'd1,
    SH_SHIFT = 2'd2
  } sh_state_e;
endpackage

// File: rtl/stx_hold.sv
module stx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              take_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (!en_i) begin
      full_q <= 1'b0;
    end else if (take_i) begin
      full_q <= 1'b0;
    end else if (wr_i && !full_q) begin
      full_q <= 1'b1;
      data_q <= data_i;
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;
endmodule

// File: rtl/stx_shift.sv
module stx_shift
  import stx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              hold_full_i,
  input  logic [DATA_W-1:0] hold_data_i,
  output logic              take_o,
  output logic              busy_o,
  output logic              tx_o
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int CNT_W   = $clog2(FRAME_W);

  sh_state_e          state_q;
  logic [FRAME_W-1:0] frame_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               last_bit;
  logic [FRAME_W-1:0] new_frame;

  assign last_bit  = (cnt_q == CNT_W'(FRAME_W - 1));
  assign new_frame = {1'b1, hold_data_i, 1'b0};
  // reload either from idle or on the tick that closes the stop bit
  assign take_o    = en_i && hold_full_i &&
                     ((state_q == SH_IDLE) ||
                      ((state_q == SH_SHIFT) && tick_i && last_bit));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SH_IDLE;
      frame_q <= '1;
      cnt_q   <= '0;
    end else if (!en_i) begin
      state_q <= SH_IDLE;
      frame_q <= '1;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        SH_IDLE: begin
          if (take_o) begin
            frame_q <= new_frame;
            state_q <= SH_ARMED;
          end
        end
        SH_ARMED: begin
          if (tick_i) begin
            state_q <= SH_SHIFT;
            cnt_q   <= '0;
          end
        end
        SH_SHIFT: begin
          if (tick_i) begin
            if (last_bit) begin
              cnt_q <= '0;
              if (take_o) begin
                frame_q <= new_frame;
              end else begin
                frame_q <= '1;
                state_q <= SH_IDLE;
              end
            end else begin
              frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
              cnt_q   <= cnt_q + CNT_W'(1);
            end
          end
        end
        default: state_q <= SH_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q == SH_SHIFT);
  assign tx_o   = (state_q == SH_SHIFT) ? frame_q[0] : 1'b1;
endmodule

// File: rtl/serial_tx_dbuf.sv
module serial_tx_dbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic              bit_tick_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              tx_empty_o,
  output logic              busy_o,
  output logic              tx_o
);
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              take;

  stx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (tx_en_i),
    .wr_i   (wr_i),
    .data_i (wr_data_i),
    .take_i (take),
    .full_o (hold_full),
    .data_o (hold_data)
  );

  stx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (tx_en_i),
    .tick_i      (bit_tick_i),
    .hold_full_i (hold_full),
    .hold_data_i (hold_data),
    .take_o      (take),
    .busy_o      (busy_o),
    .tx_o        (tx_o)
  );

  assign tx_empty_o = ~hold_full;
endmodule

// File: rtl/serial_tx_dbuf_chk.sv
module serial_tx_dbuf_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tx_en_i,
  input logic              bit_tick_i,
  input logic              wr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              tx_empty_o,
  input logic              busy_o,
  input logic              tx_o
);
  AST_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !tx_o); // R1
  AST_LINE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_i && !bit_tick_i) |=> $stable(tx_o)); // R2
  AST_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> tx_o); // R3
  AST_WRITE_FILLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_i && wr_i && tx_empty_o) |=> !tx_empty_o); // R4
  AST_ABORT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |=> (tx_o && tx_empty_o && !busy_o)); // R7
  AST_BUSY_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_i && !bit_tick_i) |=> $stable(busy_o)); // R8
endmodule

bind serial_tx_dbuf serial_tx_dbuf_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/serial_tx_dbuf_test.sv
module serial_tx_dbuf_test;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int NVEC       = 8;
  // {data written, byte expected at the receiver}
  localparam logic [15:0] VEC [NVEC] = '{
    16'h5555, 16'hA3A3, 16'h0000, 16'hFFFF,
    16'h0101, 16'h8080, 16'h3C3C, 16'hC5C5
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b1;
  logic       tick = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] din = 8'h00;
  logic       tx_empty, busy, tx;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit auto_tick = 1'b0;
  int tick_req = 0;

  int         rx_cnt = 0;
  int         rx_n = 0;
  int         tick_idx = 0;
  int         rx_st = 0;
  logic [7:0] rx_sh = 8'h00;
  logic [7:0] rx_mem [16];
  int         rx_start [16];

  serial_tx_dbuf uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .tx_en_i    (en),
    .bit_tick_i (tick),
    .wr_i       (wr),
    .wr_data_i  (din),
    .tx_empty_o (tx_empty),
    .busy_o     (busy),
    .tx_o       (tx)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // receiver model: reads the line at each tick edge, before the edge updates it
  always @(posedge clk) begin
    if (!rst_n || !en) begin
      rx_cnt = 0;
    end else if (tick) begin
      if (rx_cnt == 0) begin
        if (!tx) begin
          rx_cnt = 1;
          rx_st = tick_idx;
        end
      end else if (rx_cnt <= 8) begin
        rx_sh[rx_cnt-1] = tx;
        rx_cnt++;
      end else begin
        check(tx == 1'b1, "R1 stop bit", int'(tx), 1);
        if (rx_n < 16) begin
          rx_mem[rx_n] = rx_sh;
          rx_start[rx_n] = rx_st;
        end
        rx_n++;
        rx_cnt = 0;
      end
      tick_idx++;
    end
  end

  initial begin
    int div = 0;
    forever begin
      @(negedge clk);
      if (auto_tick) begin
        div = (div + 1) % TICK_DIV;
        tick = (div == 0);
      end else if (tick_req > 0) begin
        tick = 1'b1;
        tick_req--;
      end else begin
        tick = 1'b0;
      end
    end
  end

  task automatic write_byte(input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1;
    din = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic pulse_tick();
    tick_req = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_ticks(input int n);
    repeat (n * TICK_DIV) @(negedge clk);
  endtask

  initial begin
    logic [9:0] fbits;
    logic       prev;
    int         guard;
    int         base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(tx == 1'b1, "R3 reset tx", int'(tx), 1);
    check(tx_empty == 1'b1, "R3 reset empty", int'(tx_empty), 1);
    check(busy == 1'b0, "R3 reset busy", int'(busy), 0);

    // directed frame with hand-driven ticks
    write_byte(8'hA5);
    check(tx_empty == 1'b0, "R4 empty low after write", int'(tx_empty), 0);
    @(negedge clk);
    check(tx_empty == 1'b1, "R4 empty back after transfer", int'(tx_empty), 1);
    check(busy == 1'b0 && tx == 1'b1, "R4 waits for tick", int'({busy, tx}), 1);
    fbits = {1'b1, 8'hA5, 1'b0};
    for (int i = 0; i < 10; i++) begin
      pulse_tick();
      check(tx == fbits[i], "R1 frame bit", int'(tx), int'(fbits[i]));
      check(busy == 1'b1, "R8 busy in frame", int'(busy), 1);
      prev = tx;
      repeat (2) @(negedge clk);
      check(tx == prev, "R2 held between ticks", int'(tx), int'(prev));
    end
    pulse_tick();
    check(busy == 1'b0, "R8 busy ends after stop", int'(busy), 0);
    check(tx == 1'b1, "R3 idle after frame", int'(tx), 1);

    // vector table: streamed characters
    rx_n = 0;
    auto_tick = 1'b1;
    for (int k = 0; k < NVEC; k++) begin
      guard = 0;
      while (!tx_empty && guard < 1000) begin
        @(negedge clk);
        guard++;
      end
      write_byte(VEC[k][15:8]);
    end
    guard = 0;
    while (rx_n < NVEC && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    check(rx_n == NVEC, "R5 frame count", rx_n, NVEC);
    for (int k = 0; k < NVEC; k++) begin
      check(rx_mem[k] == VEC[k][7:0], "R1 received byte", int'(rx_mem[k]), int'(VEC[k][7:0]));
      if (k > 0)
        check(rx_start[k] - rx_start[k-1] == 10, "R5 no gap", rx_start[k] - rx_start[k-1], 10);
    end
    wait_ticks(2);
    check(busy == 1'b0 && tx == 1'b1, "R8 idle after stream", int'({busy, tx}), 1);

    // write while holding register full is ignored
    auto_tick = 1'b0;
    repeat (2) @(negedge clk);
    rx_n = 0;
    write_byte(8'h6E);
    @(negedge clk);
    write_byte(8'h19);
    check(tx_empty == 1'b0, "R6 holding full", int'(tx_empty), 0);
    write_byte(8'hE7);
    check(tx_empty == 1'b0, "R6 still full", int'(tx_empty), 0);
    auto_tick = 1'b1;
    wait_ticks(30);
    check(rx_n == 2, "R6 frame count", rx_n, 2);
    check(rx_mem[0] == 8'h6E, "R6 first byte", int'(rx_mem[0]), 'h6E);
    check(rx_mem[1] == 8'h19, "R6 pending byte unchanged", int'(rx_mem[1]), 'h19);

    // abort by clearing the enable
    rx_n = 0;
    write_byte(8'h42);
    wait_ticks(3);
    write_byte(8'h24);
    check(busy == 1'b1, "R8 busy before abort", int'(busy), 1);
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check(tx == 1'b1, "R7 line high on abort", int'(tx), 1);
    check(busy == 1'b0, "R7 busy cleared", int'(busy), 0);
    check(tx_empty == 1'b1, "R7 holding emptied", int'(tx_empty), 1);
    write_byte(8'h99);
    @(negedge clk);
    check(tx_empty == 1'b1, "R7 write ignored while off", int'(tx_empty), 1);
    wait_ticks(3);
    check(tx == 1'b1, "R7 ticks ignored while off", int'(tx), 1);
    en = 1'b1;
    base = rx_n;
    wait_ticks(15);
    check(rx_n == base, "R7 nothing sent after re-enable", rx_n, base);
    check(tx == 1'b1 && busy == 1'b0, "R3 idle after abort", int'({tx, busy}), 2);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule